// File: doc/BRIEF.md
# Low-Power Wake-Up Interrupt Controller

This block runs alongside the processor interrupt controller and decides when pending peripheral interrupt lines may release the device from a low-power state. It holds the power mode: running, a light doze, or a deep hibernate. When software asks for sleep, the block latches the target mode. It also records whether a handler was executing and, if so, that handler's priority.

While the device sleeps, a line counts as a wake source only when four conditions hold. Its peripheral-side enable and its controller-side enable are both set. The current sleep depth permits that line. When sleep began inside a handler, the line's priority must also be strictly greater than the recorded one. A non-maskable request, formed from two supply undervoltage inputs, always wakes the device. A wake produces a single-cycle pulse, and the mode returns to running on the same edge.

A sleep request is refused when some source would wake the device at once under the requested mode. The same holds when a supply fault is present.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After synchronous reset, `mode_o` is 0 (running) and `wake_pulse` is 0.
- R2: In running mode, a `sleep_req` with `sleep_mode` 1 (doze) or 2 (hibernate) sets `mode_o` to that code on the next edge. Codes 0 and 3 are ignored.
- R3: In doze, any line whose request and both enables are set wakes the device. `wake_pulse` is high for the cycle after the edge that sees the line, and `mode_o` is 0 from that same edge.
- R4: In hibernate, only lines 0, 2, 4 and 7 (parameter `HIB_MASK`, default 16'h0095) can wake. Requests on other lines leave `mode_o` at 2 and `wake_pulse` low.
- R5: Lines 1, 3 and 8 (parameter `RSV_MASK`, default 16'h010A) never wake in any mode.
- R6: A line counts only when both `irq_src_en` and `irq_ctl_en` are set for it. Either enable alone has no effect.
- R7: If `in_handler` was 1 at sleep entry, a line wakes only when its priority (`irq_prio[3*i+2:3*i]`) is strictly greater than the `run_prio` latched at entry. A larger number means higher priority, and an equal value does not wake.
- R8: If `in_handler` was 0 at sleep entry, priorities are not compared.
- R9: `nmi_req` is `uv_a` OR `uv_b`. While either sleep mode is active, an asserted `nmi_req` wakes the device whatever the line enables are.
- R10: A sleep request is ignored while `nmi_req` is high. It is also ignored while some line would qualify under the requested mode and the live `in_handler`/`run_prio`. A line that the requested mode would not permit does not block entry.
- R11: `wake_pulse` never stays high for two cycles, and a `sleep_req` while already asleep does not change `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Peripheral interrupt requests |
| irq_src_en | input | 16 | Peripheral-side request enables |
| irq_ctl_en | input | 16 | Controller-side line enables |
| irq_prio | input | 48 | 3-bit priority per line, line i at bits 3i+2..3i |
| run_prio | input | 3 | Priority of the handler running now |
| in_handler | input | 1 | A handler is executing now |
| sleep_req | input | 1 | Request to enter a sleep mode |
| sleep_mode | input | 2 | Requested mode: 1 doze, 2 hibernate |
| uv_a | input | 1 | Supply undervoltage fault A |
| uv_b | input | 1 | Supply undervoltage fault B |
| wake_pulse | output | 1 | One-cycle wake indication |
| mode_o | output | 2 | Current mode: 0 running, 1 doze, 2 hibernate |
| nmi_req | output | 1 | Non-maskable wake request |

## Verification
A sleep request and a wake source can arrive in the same cycle, and the two then compete for the mode register. The bench drives `sleep_req` while a line is already asserted with both enables. It judges the result by whether `mode_o` stays at 0, and it repeats this with a supply fault instead of a line. It then repeats the case with a line that hibernate does not permit, where the request must win and `mode_o` must become 2.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_DOZE = 2'd1,
        PM_DEEP = 2'd2
    } pmode_t;

    localparam logic [1:0] CODE_RUN  = 2'd0;
    localparam logic [1:0] CODE_DOZE = 2'd1;
    localparam logic [1:0] CODE_DEEP = 2'd2;

    // State captured when the device goes to sleep
    typedef struct packed {
        logic       hnd;
        logic [7:0] prio;
    } entry_ctx_t;

    function automatic logic mode_is_sleep(input logic [1:0] code);
        return (code == CODE_DOZE) || (code == CODE_DEEP);
    endfunction

    // Whether a line is allowed to wake under the given mode
    function automatic logic depth_permits(input pmode_t m,
                                           input logic hib_bit,
                                           input logic rsv_bit);
        logic ok;
        case (m)
            PM_DOZE: ok = !rsv_bit;
            PM_DEEP: ok = !rsv_bit && hib_bit;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/lpw_qual.sv
module lpw_qual
    import lpw_pkg::*;
#(
    parameter int                    N_LINES  = 16,
    parameter int                    PRIO_W   = 3,
    parameter logic [N_LINES-1:0]    HIB_MASK = 16'h0095,
    parameter logic [N_LINES-1:0]    RSV_MASK = 16'h010A
)(
    input  logic [N_LINES-1:0]        req,
    input  logic [N_LINES-1:0]        src_en,
    input  logic [N_LINES-1:0]        ctl_en,
    input  logic [N_LINES*PRIO_W-1:0] prio,
    input  pmode_t                    mode,
    input  logic                      use_prio,
    input  logic [PRIO_W-1:0]         ref_prio,
    output logic [N_LINES-1:0]        hit,
    output logic                      any_hit
);
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic armed;
        logic outranks;
        logic allowed;
        assign armed    = req[i] && src_en[i] && ctl_en[i];
        assign outranks = !use_prio ||
                          (prio[i*PRIO_W +: PRIO_W] > ref_prio);
        assign allowed  = depth_permits(mode, HIB_MASK[i], RSV_MASK[i]);
        assign hit[i]   = armed && outranks && allowed;
    end

    assign any_hit = |hit;
endmodule

// File: rtl/lpw_mode_fsm.sv
module lpw_mode_fsm
    import lpw_pkg::*;
#(
    parameter int PRIO_W = 3
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_req,
    input  logic [1:0]        sleep_mode,
    input  logic              entry_blocked,
    input  logic              wake_hit,
    input  logic              nmi,
    input  logic              in_handler,
    input  logic [PRIO_W-1:0] run_prio,
    output pmode_t            mode,
    output logic              ctx_hnd,
    output logic [PRIO_W-1:0] ctx_prio,
    output logic              wake_pulse
);
    pmode_t mode_q, mode_d;
    logic   hnd_q;
    logic [PRIO_W-1:0] prio_q;
    logic   pulse_d;
    logic   enter;

    assign enter = (mode_q == PM_RUN) && sleep_req &&
                   mode_is_sleep(sleep_mode) && !entry_blocked;

    always_comb begin
        mode_d  = mode_q;
        pulse_d = 1'b0;
        case (mode_q)
            PM_RUN: begin
                if (enter) mode_d = pmode_t'(sleep_mode);
            end
            PM_DOZE, PM_DEEP: begin
                if (wake_hit || nmi) begin
                    mode_d  = PM_RUN;
                    pulse_d = 1'b1;
                end
            end
            default: mode_d = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= PM_RUN;
            hnd_q      <= 1'b0;
            prio_q     <= '0;
            wake_pulse <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            wake_pulse <= pulse_d;
            if (enter) begin
                hnd_q  <= in_handler;
                prio_q <= run_prio;
            end
        end
    end

    assign mode     = mode_q;
    assign ctx_hnd  = hnd_q;
    assign ctx_prio = prio_q;
endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int                    N_LINES  = 16,
    parameter int                    PRIO_W   = 3,
    parameter logic [N_LINES-1:0]    HIB_MASK = 16'h0095,
    parameter logic [N_LINES-1:0]    RSV_MASK = 16'h010A
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_LINES-1:0]        irq_req,
    input  logic [N_LINES-1:0]        irq_src_en,
    input  logic [N_LINES-1:0]        irq_ctl_en,
    input  logic [N_LINES*PRIO_W-1:0] irq_prio,
    input  logic [PRIO_W-1:0]         run_prio,
    input  logic                      in_handler,
    input  logic                      sleep_req,
    input  logic [1:0]                sleep_mode,
    input  logic                      uv_a,
    input  logic                      uv_b,
    output logic                      wake_pulse,
    output logic [1:0]                mode_o,
    output logic                      nmi_req
);
    pmode_t              cur_mode;
    pmode_t              tgt_mode;
    logic                ctx_hnd;
    logic [PRIO_W-1:0]   ctx_prio;
    logic [N_LINES-1:0]  live_hits, pre_hits;
    logic                live_any, pre_any;

    assign nmi_req  = uv_a | uv_b;
    assign tgt_mode = mode_is_sleep(sleep_mode) ? pmode_t'(sleep_mode) : PM_RUN;

    // Wake qualification against the state latched at sleep entry
    lpw_qual #(
        .N_LINES(N_LINES), .PRIO_W(PRIO_W),
        .HIB_MASK(HIB_MASK), .RSV_MASK(RSV_MASK)
    ) u_live (
        .req(irq_req), .src_en(irq_src_en), .ctl_en(irq_ctl_en),
        .prio(irq_prio), .mode(cur_mode), .use_prio(ctx_hnd),
        .ref_prio(ctx_prio), .hit(live_hits), .any_hit(live_any)
    );

    // Look-ahead: would the requested mode be left at once
    lpw_qual #(
        .N_LINES(N_LINES), .PRIO_W(PRIO_W),
        .HIB_MASK(HIB_MASK), .RSV_MASK(RSV_MASK)
    ) u_pre (
        .req(irq_req), .src_en(irq_src_en), .ctl_en(irq_ctl_en),
        .prio(irq_prio), .mode(tgt_mode), .use_prio(in_handler),
        .ref_prio(run_prio), .hit(pre_hits), .any_hit(pre_any)
    );

    lpw_mode_fsm #(.PRIO_W(PRIO_W)) u_fsm (
        .clk(clk), .rst(rst),
        .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .entry_blocked(pre_any || nmi_req),
        .wake_hit(live_any), .nmi(nmi_req),
        .in_handler(in_handler), .run_prio(run_prio),
        .mode(cur_mode), .ctx_hnd(ctx_hnd), .ctx_prio(ctx_prio),
        .wake_pulse(wake_pulse)
    );

    assign mode_o = cur_mode;
endmodule

// File: rtl/lpw_checker.sv
module lpw_checker #(
    parameter int                    N_LINES  = 16,
    parameter logic [N_LINES-1:0]    HIB_MASK = 16'h0095,
    parameter logic [N_LINES-1:0]    RSV_MASK = 16'h010A
)(
    input logic               clk,
    input logic               rst,
    input logic [N_LINES-1:0] irq_req,
    input logic [N_LINES-1:0] irq_src_en,
    input logic [N_LINES-1:0] irq_ctl_en,
    input logic               sleep_req,
    input logic               uv_a,
    input logic               uv_b,
    input logic               wake_pulse,
    input logic [1:0]         mode_o
);
    logic [N_LINES-1:0] armed;
    assign armed = irq_req & irq_src_en & irq_ctl_en;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);                                   // R11
    AST_PULSE_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> (mode_o == 2'd0));                              // R3
    AST_FAULT_WAKES: assert property (@(posedge clk) disable iff (rst)
        ((mode_o != 2'd0) && (uv_a || uv_b)) |=> wake_pulse);          // R9
    AST_DEEP_FILTER: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 2'd2) && ((armed & HIB_MASK & ~RSV_MASK) == '0) && !uv_a && !uv_b)
        |=> (!wake_pulse && mode_o == 2'd2));                          // R4
    AST_RSV_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 2'd1) && ((armed & ~RSV_MASK) == '0) && !uv_a && !uv_b)
        |=> !wake_pulse);                                              // R5
    AST_NEED_BOTH_EN: assert property (@(posedge clk) disable iff (rst)
        ((mode_o != 2'd0) && (armed == '0) && !uv_a && !uv_b)
        |=> !wake_pulse);                                              // R6
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 2'd0) && !sleep_req) |=> (mode_o == 2'd0));       // R2
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (rst)
        ((mode_o == 2'd0) && sleep_req && (uv_a || uv_b)) |=> (mode_o == 2'd0)); // R10
endmodule

bind lp_wake_ctrl lpw_checker #(
    .N_LINES(N_LINES), .HIB_MASK(HIB_MASK), .RSV_MASK(RSV_MASK)
) u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_src_en(irq_src_en),
    .irq_ctl_en(irq_ctl_en), .sleep_req(sleep_req), .uv_a(uv_a),
    .uv_b(uv_b), .wake_pulse(wake_pulse), .mode_o(mode_o)
);

// File: tb/lp_wake_ctrl_test.sv
module lp_wake_ctrl_test;
    localparam int N = 16;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  irq_req, irq_src_en, irq_ctl_en;
    logic [N*PW-1:0] irq_prio;
    logic [PW-1:0] run_prio;
    logic          in_handler, sleep_req, uv_a, uv_b;
    logic [1:0]    sleep_mode;
    logic          wake_pulse, nmi_req;
    logic [1:0]    mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    lp_wake_ctrl uut (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_src_en(irq_src_en),
        .irq_ctl_en(irq_ctl_en), .irq_prio(irq_prio), .run_prio(run_prio),
        .in_handler(in_handler), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .uv_a(uv_a), .uv_b(uv_b), .wake_pulse(wake_pulse), .mode_o(mode_o),
        .nmi_req(nmi_req)
    );

    // {tgt[2], hnd, run_prio[3], req[16], src_en[16], ctl_en[16], line_prio[3], uv, exp_wake}
    localparam int VW = 59;
    localparam int NV = 13;
    localparam logic [VW-1:0] VT [NV] = '{
        {2'd1, 1'b0, 3'd0, 16'h0200, 16'h0200, 16'h0200, 3'd0, 1'b0, 1'b1}, // R3 line 9 doze
        {2'd2, 1'b0, 3'd0, 16'h0200, 16'h0200, 16'h0200, 3'd0, 1'b0, 1'b0}, // R4 line 9 deep
        {2'd2, 1'b0, 3'd0, 16'h0001, 16'h0001, 16'h0001, 3'd0, 1'b0, 1'b1}, // R4 line 0 deep
        {2'd2, 1'b0, 3'd0, 16'h0080, 16'h0080, 16'h0080, 3'd0, 1'b0, 1'b1}, // R4 line 7 deep
        {2'd1, 1'b0, 3'd0, 16'h0008, 16'h0008, 16'h0008, 3'd0, 1'b0, 1'b0}, // R5 line 3
        {2'd1, 1'b0, 3'd0, 16'h0100, 16'h0100, 16'h0100, 3'd0, 1'b0, 1'b0}, // R5 line 8
        {2'd1, 1'b0, 3'd0, 16'h0020, 16'h0020, 16'h0000, 3'd0, 1'b0, 1'b0}, // R6 src only
        {2'd1, 1'b0, 3'd0, 16'h0020, 16'h0000, 16'h0020, 3'd0, 1'b0, 1'b0}, // R6 ctl only
        {2'd1, 1'b1, 3'd3, 16'h0020, 16'h0020, 16'h0020, 3'd3, 1'b0, 1'b0}, // R7 equal
        {2'd1, 1'b1, 3'd3, 16'h0020, 16'h0020, 16'h0020, 3'd4, 1'b0, 1'b1}, // R7 higher
        {2'd1, 1'b0, 3'd7, 16'h0020, 16'h0020, 16'h0020, 3'd0, 1'b0, 1'b1}, // R8 bypass
        {2'd2, 1'b0, 3'd0, 16'h0000, 16'h0000, 16'h0000, 3'd0, 1'b1, 1'b1}, // R9 fault
        {2'd2, 1'b1, 3'd6, 16'h0004, 16'h0004, 16'h0004, 3'd7, 1'b0, 1'b1}  // R7 deep line 2
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        irq_req = '0; irq_src_en = '0; irq_ctl_en = '0; irq_prio = '0;
        run_prio = '0; in_handler = 0; sleep_req = 0; sleep_mode = 0;
        uv_a = 0; uv_b = 0;
    endtask

    task automatic cycle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1; cycle(); cycle(); rst = 0;
    endtask

    task automatic ask_sleep(input logic [1:0] m);
        sleep_req = 1; sleep_mode = m; cycle(); sleep_req = 0; sleep_mode = 0;
    endtask

    initial begin
        rst = 1;
        idle_inputs();
        @(negedge clk);
        do_reset();
        chk(mode_o == 2'd0, "R1 mode", mode_o, 0);
        chk(wake_pulse == 1'b0, "R1 wake", wake_pulse, 0);

        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            logic [1:0] tgt;
            e = VT[v];
            tgt = e[58:57];
            do_reset();
            in_handler = e[56]; run_prio = e[55:53];
            ask_sleep(tgt);
            in_handler = 0; run_prio = 0;
            chk(mode_o == tgt, "R2 entry", mode_o, tgt);
            irq_req = e[52:37]; irq_src_en = e[36:21]; irq_ctl_en = e[20:5];
            irq_prio = {N{e[4:2]}};
            uv_a = e[1];
            cycle();
            chk(wake_pulse == e[0], "R3/R4/R5/R6/R7/R8/R9 wake", wake_pulse, e[0]);
            chk(mode_o == (e[0] ? 2'd0 : tgt), "R3 mode after", mode_o, e[0] ? 0 : tgt);
            cycle();
            chk(wake_pulse == 1'b0, "R11 single pulse", wake_pulse, 0);
        end

        // R2: codes 0 and 3 ignored
        do_reset();
        ask_sleep(2'd0);
        chk(mode_o == 2'd0, "R2 code0", mode_o, 0);
        ask_sleep(2'd3);
        chk(mode_o == 2'd0, "R2 code3", mode_o, 0);

        // R9: output is OR of faults
        uv_b = 1; #1;
        chk(nmi_req == 1'b1, "R9 nmi uv_b", nmi_req, 1);
        uv_b = 0; #1;
        chk(nmi_req == 1'b0, "R9 nmi clear", nmi_req, 0);

        // R10: pending line blocks entry
        do_reset();
        irq_req = 16'h0020; irq_src_en = 16'h0020; irq_ctl_en = 16'h0020;
        ask_sleep(2'd1);
        chk(mode_o == 2'd0, "R10 line blocks", mode_o, 0);
        // R10: fault blocks entry
        do_reset();
        uv_a = 1;
        ask_sleep(2'd2);
        uv_a = 0;
        chk(mode_o == 2'd0, "R10 fault blocks", mode_o, 0);
        // R10: line not permitted in hibernate does not block
        do_reset();
        irq_req = 16'h0200; irq_src_en = 16'h0200; irq_ctl_en = 16'h0200;
        ask_sleep(2'd2);
        chk(mode_o == 2'd2, "R10 deep enters", mode_o, 2);
        // R10: live handler priority too low does not block
        do_reset();
        in_handler = 1; run_prio = 3'd5;
        irq_req = 16'h0020; irq_src_en = 16'h0020; irq_ctl_en = 16'h0020;
        irq_prio = {N{3'd5}};
        ask_sleep(2'd1);
        chk(mode_o == 2'd1, "R10 low prio enters", mode_o, 1);

        // R11: request while asleep ignored
        do_reset();
        ask_sleep(2'd1);
        ask_sleep(2'd2);
        chk(mode_o == 2'd1, "R11 no reentry", mode_o, 1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule